// File: doc/BRIEF.md
# CAN Bus Error Status Register

This block is the status register that a CAN protocol controller shows to its host processor. It records the kind of the most recent bus error as a 3-bit code. It also keeps two sticky flags: one for a successful transmission and one for a successful reception. The protocol engine drives single-cycle event pulses into the block:

- one pulse line for each error kind;
- one pulse for an error-free, acknowledged transmission;
- one pulse for an error-free reception;
- one pulse for each run of 11 recessive bits seen during bus-off recovery.

The host reads and writes the register through a simple synchronous port. A read returns the whole register combinationally.

The host can load code 7 into the code field. Hardware never produces that value, so a later change away from 7 shows that a bus event has happened since the write. The host can only clear the success flags. Hardware only sets them. When a hardware event and a host write touch the same field in the same cycle, the hardware event wins, so no event is lost.

Top module: `can_err_status`

## Requirements
- R1: After reset every bit of `rd_data_o` reads 0.
- R2: A pulse on `err_ev_i[k]` records code k+1 in bits 2:0 one cycle later. The codes are: 1 stuff (more than five equal consecutive bits in a stuffed region), 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC.
- R3: When several error pulses (including the recovery pulse, which counts as code 5) arrive in one cycle, the highest code among them is recorded.
- R4: A pulse on `recov_ev_i` (11 recessive bits seen during bus-off recovery) records code 5.
- R5: A pulse on `tx_ok_i` or `rx_ok_i` clears bits 2:0 to 0, unless an error or recovery pulse comes in the same cycle, in which case the error code is recorded.
- R6: With no hardware event, `wr_en_i` loads `wr_data_i[2:0]` into the code field. A written 7 is then held until a bus event changes it.
- R7: A hardware event on the code field takes priority over a host write in the same cycle.
- R8: `tx_ok_i` sets the transmit flag (bit 3) and `rx_ok_i` sets the receive flag (bit 4). Each flag stays set until the host clears it.
- R9: A host write with 0 in bit 3 or bit 4 clears that flag. A write with 1 in that bit leaves the flag unchanged.
- R10: A set pulse wins over a host clear of the same flag in the same cycle.
- R11: Bits above bit 4 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_ev_i | input | 6 | Error pulses; bit k reports code k+1 |
| recov_ev_i | input | 1 | 11-recessive-bit run during bus-off recovery |
| tx_ok_i | input | 1 | Error-free, acknowledged transmission |
| rx_ok_i | input | 1 | Error-free reception |
| wr_en_i | input | 1 | Host register write strobe |
| wr_data_i | input | 32 | Host write data |
| rd_data_o | output | 32 | Register read value |

## Verification
The bench targets the cycles in which events collide:

- **Error and success pulse together.** A design that let the success pulse win would wrongly read code 0.
- **Recovery pulse together with a CRC pulse.** A design with the wrong priority would report 5 where 6 is due.
- **Host write in the same cycle as a hardware event.** A design that let the write win would drop the event.

It also writes 7 and then checks that the code stays 7 until an event arrives. It writes 1s to the flag bits and expects no change, since a plain load would clear or set them wrongly. Upper-bit writes must keep reading back 0.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int unsigned CODE_W      = 3;
  localparam int unsigned NUM_ERR     = 6;
  localparam int unsigned TXF_BIT     = CODE_W;
  localparam int unsigned RXF_BIT     = CODE_W + 1;
  localparam int unsigned USED_W      = CODE_W + 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'd0,
    CODE_STUFF = 3'd1,
    CODE_FORM  = 3'd2,
    CODE_ACK   = 3'd3,
    CODE_BIT1  = 3'd4,
    CODE_BIT0  = 3'd5,
    CODE_CRC   = 3'd6,
    CODE_MARK  = 3'd7
  } err_code_e;
endpackage

// File: rtl/can_err_prio.sv
module can_err_prio
  import can_stat_pkg::*;
#(
  parameter int unsigned N = NUM_ERR
) (
  input  logic [N-1:0]      hits_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  // highest set index wins: later iterations override earlier ones
  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hits_i[i]) code_o = CODE_W'(i + 1);
    end
  end
  assign any_o = |hits_i;
endmodule

// File: rtl/can_sticky_flag.sv
module can_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (flag_en) flag_o <= flag_d;
  end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_ERR-1:0] err_ev_i,
  input  logic              recov_ev_i,
  input  logic              tx_ok_i,
  input  logic              rx_ok_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned RECOV_IDX = int'(CODE_BIT0) - 1;

  logic [NUM_ERR-1:0] hits;
  logic               hw_err;
  logic [CODE_W-1:0]  enc_code;
  logic [CODE_W-1:0]  code_d, code_q;
  logic               code_en;
  logic [1:0]         flag_set, flag_clr, flag_q;
  logic               unused_wr_bits;

  always_comb begin
    hits = err_ev_i;
    hits[RECOV_IDX] = err_ev_i[RECOV_IDX] | recov_ev_i;
  end

  can_err_prio #(.N(NUM_ERR)) u_prio (
    .hits_i (hits),
    .any_o  (hw_err),
    .code_o (enc_code)
  );

  // next-state of the code field: error > success clear > host write
  always_comb begin
    code_en = hw_err | tx_ok_i | rx_ok_i | wr_en_i;
    if (hw_err)                 code_d = enc_code;
    else if (tx_ok_i | rx_ok_i) code_d = CODE_NONE;
    else                        code_d = wr_data_i[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign flag_set = {rx_ok_i, tx_ok_i};
  assign flag_clr = {wr_en_i & ~wr_data_i[RXF_BIT], wr_en_i & ~wr_data_i[TXF_BIT]};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    can_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  assign unused_wr_bits = ^wr_data_i[DATA_W-1:USED_W];
  assign rd_data_o = {{(DATA_W-USED_W){1'b0}}, flag_q, code_q};

  // R2
  err_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_ev_i) |=> (rd_data_o[CODE_W-1:0] != CODE_NONE));
  // R4
  recov_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_ev_i && !err_ev_i[NUM_ERR-1]) |=> (rd_data_o[CODE_W-1:0] == CODE_BIT0));
  // R5
  ok_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ok_i || rx_ok_i) && !(|err_ev_i) && !recov_ev_i) |=> (rd_data_o[CODE_W-1:0] == CODE_NONE));
  // R6
  mark_only_by_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MARK && $past(code_q) != CODE_MARK) |-> $past(wr_en_i));
  // R8
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok_i |=> rd_data_o[TXF_BIT]);
  // R9
  tx_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(wr_en_i && !wr_data_i[TXF_BIT]));
  // R9
  rx_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(wr_en_i && !wr_data_i[RXF_BIT]));
endmodule

// File: tb/can_err_status_tb.sv
module can_err_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    err_ev;
  logic          recov, txok, rxok, wen;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  int m_code, m_tx, m_rx;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_status #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_ev_i(err_ev), .recov_ev_i(recov),
    .tx_ok_i(txok), .rx_ok_i(rxok), .wr_en_i(wen), .wr_data_i(wdata),
    .rd_data_o(rdata)
  );

  function automatic int expect_word();
    return m_code + 8 * m_tx + 16 * m_rx;
  endfunction

  task automatic check(input string req, input int exp_val);
    checks++;
    if (rdata !== DW'(exp_val)) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, rdata, exp_val);
    end
  endtask

  // behavioural reference: apply the rules to the applied inputs
  task automatic model_update();
    int top = 0;
    for (int k = 0; k < 6; k++) if (err_ev[k]) top = k + 1;
    if (recov && top < 5) top = 5;
    if (top != 0) m_code = top;
    else if (txok || rxok) m_code = 0;
    else if (wen) m_code = int'(wdata[2:0]);
    if (txok) m_tx = 1; else if (wen && !wdata[3]) m_tx = 0;
    if (rxok) m_rx = 1; else if (wen && !wdata[4]) m_rx = 0;
  endtask

  task automatic step(input logic [5:0] e, input logic rc, input logic t,
                      input logic r, input logic w, input logic [DW-1:0] d,
                      input string req);
    err_ev = e; recov = rc; txok = t; rxok = r; wen = w; wdata = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(req, expect_word());
    err_ev = '0; recov = 0; txok = 0; rxok = 0; wen = 0; wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; err_ev = '0; recov = 0; txok = 0; rxok = 0; wen = 0; wdata = '0;
    m_code = 0; m_tx = 0; m_rx = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 0);
    for (int k = 0; k < 6; k++) step(6'(1 << k), 0, 0, 0, 0, '0, "R2 single error");
    step(6'b001011, 0, 0, 0, 0, '0, "R3 highest of 1,2,4");
    step(6'b100000, 1, 0, 0, 0, '0, "R3 crc beats recovery");
    step(6'b000010, 1, 0, 0, 0, '0, "R3 recovery beats form");
    step('0, 1, 0, 0, 0, '0, "R4 recovery code 5");
    step('0, 0, 1, 0, 0, '0, "R5 tx clears code, R8 tx flag");
    step(6'b000100, 0, 0, 0, 0, '0, "R2 ack");
    step('0, 0, 0, 1, 0, '0, "R5 rx clears code, R8 rx flag");
    step(6'b000001, 0, 1, 0, 0, '0, "R5 error beats success");
    step('0, 0, 0, 0, 1, 32'h0000_001F, "R6 write 7 keep flags R9");
    step('0, 0, 0, 0, 0, '0, "R6 mark holds");
    step('0, 0, 0, 0, 0, '0, "R6 mark holds again");
    step(6'b000010, 0, 0, 0, 1, 32'h0000_001F, "R7 event beats write");
    step('0, 0, 0, 0, 1, 32'h0000_0010, "R9 clear tx only");
    step('0, 0, 0, 0, 1, 32'h0000_0007, "R9 clear rx");
    step('0, 0, 1, 1, 1, 32'h0000_0000, "R10 set beats clear");
    step('0, 0, 0, 0, 1, 32'hFFFF_FFE3, "R11 upper bits read zero");
    step('0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R11 upper ignored");
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] e;
      e = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
      step(e, ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0),
           $urandom, "R2-R11 random (R3 R5 R7 R10)");
    end
    rst_n = 0;
    @(negedge clk);
    m_code = 0; m_tx = 0; m_rx = 0;
    check("R1 reset again", 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule